// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO with Replay

This block carries 36-bit words from a write port on one clock to a read port on a second, independent clock. The two clocks may be unrelated or the same net. When they are the same net, a write and a read can both complete on one edge. The read side works in first-word-fall-through fashion. The oldest stored word is already on the read data bus, marked valid, before any read is requested. A read command consumes that word and brings the next one forward.

Each port has a select, a direction bit and an enable. On the write port, the direction bit chooses between storing a word and loading the two flag thresholds. On the read port, it chooses between consuming the head word and setting a replay mark at the head word. A separate rewind input moves the read position back to the mark, so the marked words are delivered again. Until the next mark, the words from the mark onward keep occupying storage space, so a replay always finds its data intact.

Write-side ready and almost-full are registered on the write clock. Read-side valid and almost-empty are registered on the read clock. The write pointer and the trailing copy of the mark cross the clock boundary as Gray codes. Because of this, each flag can report late but never optimistically.

Top module: `dcf_retx_fifo`

## Requirements
- R1: While reset is held, a_ready and b_valid are 0, b_almost_empty is 1 and a_almost_full is 0. Once reset is released and has settled, a_ready is 1 and the thresholds hold the values AF_DEFAULT and AE_DEFAULT.
- R2: A stored word appears on b_data with b_valid high without any read command being given.
- R3: Words leave in the order they were written. b_valid falls in the read-clock edge that consumes the last stored word.
- R4: A write is a_sel, a_en and a_wr all high at a clk_a edge while a_ready is high. a_ready falls in the same edge that makes the count of words held since the mark equal DEPTH. A write attempted while a_ready is low stores nothing.
- R5: a_almost_full is 1 when the free space (DEPTH minus the words held since the mark) is at or below the almost-full threshold. It is updated in the same clk_a edge as the write that changes the space.
- R6: b_almost_empty is 1 when the number of unread words is at or below the almost-empty threshold.
- R7: a_sel and a_en high with a_wr low is a threshold load. The almost-full threshold is taken from a_data bits [ADDR_W-1:0] and the almost-empty threshold from a_data bits [16+ADDR_W-1:16]. No word is stored.
- R8: A read is b_sel, b_en and b_rd all high at a clk_b edge while b_valid is high. With b_en low, the head word stays in place.
- R9: b_sel and b_en high with b_rd low sets the mark at the current head word. A b_rewind pulse returns the read position to the mark, so the words from there on are delivered again. b_rewind takes priority over read and mark commands in the same cycle.
- R10: Words from the mark onward count as occupied on the write side even after they have been read. Space is released only when a later mark moves past them.
- R11: Pointers cross the clock boundary as Gray codes that change by at most one bit per source edge. A word just written does not show as valid on the read side before the crossing delay has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-port clock |
| clk_b | input | 1 | Read-port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in each domain by a synchronizer |
| a_sel | input | 1 | Write-port select |
| a_wr | input | 1 | Write-port direction: 1 stores a word, 0 loads thresholds |
| a_en | input | 1 | Write-port enable |
| a_data | input | DATA_W | Write data or threshold fields |
| a_ready | output | 1 | Space available for a write |
| a_almost_full | output | 1 | Free space at or below the almost-full threshold |
| b_sel | input | 1 | Read-port select |
| b_rd | input | 1 | Read-port direction: 1 consumes the head word, 0 sets the mark |
| b_en | input | 1 | Read-port enable |
| b_rewind | input | 1 | Return the read position to the mark |
| b_data | output | DATA_W | Head word of the FIFO |
| b_valid | output | 1 | b_data holds a stored word |
| b_almost_empty | output | 1 | Unread words at or below the almost-empty threshold |

## Verification
The assertions watch the properties that must hold on every edge. The words held never exceed the capacity, as seen from the write side. The read pointer never passes the synchronized write pointer. Each Gray-coded pointer moves by at most one bit per source edge. The trailing copy of the mark stays behind the read pointer. A rewind lands on the mark, and refused writes and reads leave their pointers unchanged. The bench scenarios are the only way to show the rest: data order and values across a replay, exact flag thresholds after a threshold load, and the space that stays held after reading until a new mark.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

   // Write-port command decoded from select, enable and direction
   typedef enum logic [1:0] {
      A_IDLE,
      A_PUSH,
      A_PROG
   } a_cmd_e;

   // Read-port command; rewind outranks the others
   typedef enum logic [1:0] {
      B_IDLE,
      B_POP,
      B_MARK,
      B_REWIND
   } b_cmd_e;

   // Bit position of the almost-empty threshold field in a load word
   localparam int unsigned AE_FIELD_LSB = 16;

endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dcf_rst_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign srst_n = chain[STAGES-1];

endmodule

// File: rtl/dcf_gray_cross.sv
module dcf_gray_cross #(
   parameter int unsigned W      = 10,
   parameter int unsigned STAGES = 2
) (
   input  logic         src_clk,
   input  logic         src_rst_n,
   input  logic [W-1:0] src_bin,
   input  logic         dst_clk,
   input  logic         dst_rst_n,
   output logic [W-1:0] dst_bin
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dcf_gray_cross: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0]                src_gray;
   logic [STAGES-1:0][W-1:0]    stage;

   // Gray register in the source domain: no combinational path crosses
   always_ff @(posedge src_clk or negedge src_rst_n) begin
      if (!src_rst_n) src_gray <= '0;
      else            src_gray <= src_bin ^ (src_bin >> 1);
   end

   always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) stage <= '0;
      else            stage <= {stage[STAGES-2:0], src_gray};
   end

   always_comb begin
      for (int i = 0; i < int'(W); i++) begin
         dst_bin[i] = ^(stage[STAGES-1] >> i);
      end
   end

   // R11: the code seen by the other domain changes at most one bit per source edge
   a_r11_gray_single_step: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      $onehot0(src_gray ^ $past(src_gray)));

endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
   import dcf_pkg::*;
#(
   parameter int unsigned DATA_W     = 36,
   parameter int unsigned ADDR_W     = 9,
   parameter int unsigned AF_DEFAULT = 8,
   parameter int unsigned AE_DEFAULT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic              en,
   input  logic [DATA_W-1:0] din,
   input  logic [ADDR_W:0]   mark_bin,
   output logic              ready,
   output logic              almost_full,
   output logic              push,
   output logic [ADDR_W:0]   wptr,
   output logic [ADDR_W-1:0] ae_ofs
);

   localparam int unsigned     PW  = ADDR_W + 1;
   localparam logic [PW-1:0]   CAP = PW'(2 ** ADDR_W);

   a_cmd_e            cmd;
   logic [ADDR_W-1:0] af_ofs;
   logic [PW-1:0]     wptr_nx;
   logic [PW-1:0]     used_nx;
   logic [PW-1:0]     free_nx;

   always_comb begin
      if (!(sel && en)) cmd = A_IDLE;
      else if (wr)      cmd = A_PUSH;
      else              cmd = A_PROG;
   end

   assign push    = (cmd == A_PUSH) && ready;
   assign wptr_nx = wptr + PW'(push);
   // Occupancy is counted from the replay mark, not from the read pointer
   assign used_nx = wptr_nx - mark_bin;
   assign free_nx = CAP - used_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr        <= '0;
         ready       <= 1'b0;
         almost_full <= 1'b0;
         af_ofs      <= ADDR_W'(AF_DEFAULT);
         ae_ofs      <= ADDR_W'(AE_DEFAULT);
      end else begin
         wptr        <= wptr_nx;
         ready       <= used_nx < CAP;
         almost_full <= free_nx <= PW'(af_ofs);
         if (cmd == A_PROG) begin
            af_ofs <= din[ADDR_W-1:0];
            ae_ofs <= din[AE_FIELD_LSB +: ADDR_W];
         end
      end
   end

   // R4: the write side never holds more than the capacity past the mark
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (wptr - mark_bin) <= CAP);

   // R4: a store request while not ready leaves the write pointer alone
   a_r4_ignored_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == A_PUSH && !ready) |=> (wptr == $past(wptr)));

   // R5: reaching full always comes with almost-full
   a_r5_full_implies_af: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> almost_full);

endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
   import dcf_pkg::*;
#(
   parameter int unsigned ADDR_W      = 9,
   parameter int unsigned AE_DEFAULT  = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              rd,
   input  logic              en,
   input  logic              rewind,
   input  logic [ADDR_W:0]   wr_bin,
   input  logic [ADDR_W-1:0] ae_ofs_src,
   output logic              valid,
   output logic              almost_empty,
   output logic [ADDR_W:0]   rptr,
   output logic [ADDR_W:0]   mark_trail
);

   localparam int unsigned   PW  = ADDR_W + 1;
   localparam logic [PW-1:0] CAP = PW'(2 ** ADDR_W);

   b_cmd_e                             cmd;
   logic                               pop;
   logic [PW-1:0]                      rptr_nx;
   logic [PW-1:0]                      mark_tgt;
   logic [PW-1:0]                      mark_tgt_nx;
   logic [PW-1:0]                      avail_nx;
   logic [SYNC_STAGES-1:0][ADDR_W-1:0] ae_chain;

   always_comb begin
      if (rewind)            cmd = B_REWIND;
      else if (!(sel && en)) cmd = B_IDLE;
      else if (rd)           cmd = B_POP;
      else                   cmd = B_MARK;
   end

   assign pop         = (cmd == B_POP) && valid;
   assign rptr_nx     = (cmd == B_REWIND) ? mark_tgt : rptr + PW'(pop);
   assign mark_tgt_nx = (cmd == B_MARK) ? rptr : mark_tgt;
   assign avail_nx    = wr_bin - rptr_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr         <= '0;
         mark_tgt     <= '0;
         mark_trail   <= '0;
         valid        <= 1'b0;
         almost_empty <= 1'b1;
         ae_chain     <= {SYNC_STAGES{ADDR_W'(AE_DEFAULT)}};
      end else begin
         rptr         <= rptr_nx;
         mark_tgt     <= mark_tgt_nx;
         // The crossing copy walks one step per edge so its Gray code moves one bit
         mark_trail   <= (mark_trail != mark_tgt) ? mark_trail + PW'(1) : mark_trail;
         valid        <= avail_nx != '0;
         almost_empty <= avail_nx <= PW'(ae_chain[SYNC_STAGES-1]);
         ae_chain     <= {ae_chain[SYNC_STAGES-2:0], ae_ofs_src};
      end
   end

   // R9: a rewind lands on the mark held before the edge
   a_r9_rewind_target: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == B_REWIND) |=> (rptr == $past(mark_tgt)));

   // R3: the read pointer never runs past the synchronized write pointer
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bin - rptr) <= CAP);

   // R2: valid is only shown while a stored word sits at the head
   a_r2_valid_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (wr_bin != rptr));

   // R8: a read request with nothing valid leaves the pointer alone
   a_r8_pop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == B_POP && !valid) |=> (rptr == $past(rptr)));

   // R10: the crossing copy of the mark trails the target, which trails the read pointer
   a_r10_mark_behind_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_tgt - mark_trail) <= (rptr - mark_trail));

endmodule

// File: rtl/dcf_retx_fifo.sv
module dcf_retx_fifo
   import dcf_pkg::*;
#(
   parameter int unsigned DATA_W      = 36,
   parameter int unsigned DEPTH       = 512,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned AF_DEFAULT  = 8,
   parameter int unsigned AE_DEFAULT  = 8
) (
   input  logic              clk_a,
   input  logic              clk_b,
   input  logic              rst_n,
   input  logic              a_sel,
   input  logic              a_wr,
   input  logic              a_en,
   input  logic [DATA_W-1:0] a_data,
   output logic              a_ready,
   output logic              a_almost_full,
   input  logic              b_sel,
   input  logic              b_rd,
   input  logic              b_en,
   input  logic              b_rewind,
   output logic [DATA_W-1:0] b_data,
   output logic              b_valid,
   output logic              b_almost_empty
);

   localparam int unsigned ADDR_W = $clog2(DEPTH);
   localparam int unsigned PW     = ADDR_W + 1;

   generate
      if (DEPTH < 4 || (2 ** ADDR_W) != DEPTH) begin : g_bad_depth
         $error("dcf_retx_fifo: DEPTH must be a power of two of at least 4");
      end
      if (DATA_W < AE_FIELD_LSB + ADDR_W) begin : g_bad_width
         $error("dcf_retx_fifo: DATA_W too narrow for the threshold load fields");
      end
      if (AF_DEFAULT >= DEPTH || AE_DEFAULT >= DEPTH) begin : g_bad_default
         $error("dcf_retx_fifo: default thresholds must be below DEPTH");
      end
   endgenerate

   logic              rst_a_n;
   logic              rst_b_n;
   logic              push;
   logic [PW-1:0]     wptr;
   logic [PW-1:0]     wptr_b;
   logic [PW-1:0]     rptr;
   logic [PW-1:0]     mark_trail;
   logic [PW-1:0]     mark_a;
   logic [ADDR_W-1:0] ae_ofs_a;
   logic [DATA_W-1:0] mem [DEPTH];

   dcf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_a (
      .clk    (clk_a),
      .arst_n (rst_n),
      .srst_n (rst_a_n)
   );

   dcf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_b (
      .clk    (clk_b),
      .arst_n (rst_n),
      .srst_n (rst_b_n)
   );

   dcf_wr_side #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .AF_DEFAULT (AF_DEFAULT),
      .AE_DEFAULT (AE_DEFAULT)
   ) u_wr (
      .clk         (clk_a),
      .rst_n       (rst_a_n),
      .sel         (a_sel),
      .wr          (a_wr),
      .en          (a_en),
      .din         (a_data),
      .mark_bin    (mark_a),
      .ready       (a_ready),
      .almost_full (a_almost_full),
      .push        (push),
      .wptr        (wptr),
      .ae_ofs      (ae_ofs_a)
   );

   dcf_rd_side #(
      .ADDR_W      (ADDR_W),
      .AE_DEFAULT  (AE_DEFAULT),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_rd (
      .clk          (clk_b),
      .rst_n        (rst_b_n),
      .sel          (b_sel),
      .rd           (b_rd),
      .en           (b_en),
      .rewind       (b_rewind),
      .wr_bin       (wptr_b),
      .ae_ofs_src   (ae_ofs_a),
      .valid        (b_valid),
      .almost_empty (b_almost_empty),
      .rptr         (rptr),
      .mark_trail   (mark_trail)
   );

   dcf_gray_cross #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_x (
      .src_clk   (clk_a),
      .src_rst_n (rst_a_n),
      .src_bin   (wptr),
      .dst_clk   (clk_b),
      .dst_rst_n (rst_b_n),
      .dst_bin   (wptr_b)
   );

   dcf_gray_cross #(.W(PW), .STAGES(SYNC_STAGES)) u_mark_x (
      .src_clk   (clk_b),
      .src_rst_n (rst_b_n),
      .src_bin   (mark_trail),
      .dst_clk   (clk_a),
      .dst_rst_n (rst_a_n),
      .dst_bin   (mark_a)
   );

   // Storage is written on the write clock. The head word is read without a register,
   // so the output falls through as soon as the read pointer moves.
   always_ff @(posedge clk_a) begin
      if (push) mem[wptr[ADDR_W-1:0]] <= a_data;
   end

   assign b_data = mem[rptr[ADDR_W-1:0]];

endmodule

// File: tb/dcf_retx_fifo_test.sv
module dcf_retx_fifo_test;

   localparam int unsigned DW    = 36;
   localparam int unsigned DEPTH = 16;
   localparam int unsigned AFD   = 3;
   localparam int unsigned AED   = 3;

   logic clk_a = 1'b0;
   logic clk_b = 1'b0;
   logic rst_n = 1'b1;
   logic a_sel = 1'b0, a_wr = 1'b0, a_en = 1'b0;
   logic [DW-1:0] a_data = '0;
   logic a_ready, a_almost_full;
   logic b_sel = 1'b0, b_rd = 1'b0, b_en = 1'b0, b_rewind = 1'b0;
   logic [DW-1:0] b_data;
   logic b_valid, b_almost_empty;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk_a = ~clk_a;   // 125 MHz write clock
   always #5 clk_b = ~clk_b;   // independent read clock

   dcf_retx_fifo #(
      .DATA_W (DW), .DEPTH (DEPTH), .SYNC_STAGES (2),
      .AF_DEFAULT (AFD), .AE_DEFAULT (AED)
   ) uut (
      .clk_a, .clk_b, .rst_n,
      .a_sel, .a_wr, .a_en, .a_data, .a_ready, .a_almost_full,
      .b_sel, .b_rd, .b_en, .b_rewind, .b_data, .b_valid, .b_almost_empty
   );

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic a_cmd(input logic wr, input logic [DW-1:0] d);
      @(negedge clk_a);
      a_sel = 1'b1; a_wr = wr; a_en = 1'b1; a_data = d;
      @(negedge clk_a);
      a_sel = 1'b0; a_en = 1'b0;
   endtask

   task automatic push(input logic [DW-1:0] d);
      a_cmd(1'b1, d);
   endtask

   task automatic pop_chk(input logic [DW-1:0] exp, input string req);
      @(negedge clk_b);
      chk(b_valid === 1'b1, req, DW'(b_valid), DW'(1));
      chk(b_data === exp, req, b_data, exp);
      b_sel = 1'b1; b_rd = 1'b1; b_en = 1'b1;
      @(negedge clk_b);
      b_sel = 1'b0; b_en = 1'b0;
   endtask

   task automatic set_mark();
      @(negedge clk_b);
      b_sel = 1'b1; b_rd = 1'b0; b_en = 1'b1;
      @(negedge clk_b);
      b_sel = 1'b0; b_en = 1'b0;
   endtask

   task automatic do_rewind();
      @(negedge clk_b);
      b_rewind = 1'b1;
      @(negedge clk_b);
      b_rewind = 1'b0;
   endtask

   task automatic settle();
      repeat (40) @(negedge clk_b);
      @(negedge clk_a);
   endtask

   task automatic t_reset();
      #1 rst_n = 1'b0;
      repeat (4) @(negedge clk_a);
      chk(a_ready === 1'b0, "R1 ready in reset", DW'(a_ready), DW'(0));
      chk(b_valid === 1'b0, "R1 valid in reset", DW'(b_valid), DW'(0));
      chk(b_almost_empty === 1'b1, "R1 ae in reset", DW'(b_almost_empty), DW'(1));
      chk(a_almost_full === 1'b0, "R1 af in reset", DW'(a_almost_full), DW'(0));
      rst_n = 1'b1;
      settle();
      chk(a_ready === 1'b1, "R1 ready after reset", DW'(a_ready), DW'(1));
      chk(b_valid === 1'b0, "R1 valid after reset", DW'(b_valid), DW'(0));
   endtask

   task automatic t_fall_through();
      push(36'hA_0000_0000);
      // R11: the read side cannot see the word before the crossing delay
      chk(b_valid === 1'b0, "R11 valid lags write", DW'(b_valid), DW'(0));
      settle();
      chk(b_valid === 1'b1, "R2 valid without read", DW'(b_valid), DW'(1));
      chk(b_data === 36'hA_0000_0000, "R2 head word shown", b_data, 36'hA_0000_0000);
      chk(b_almost_empty === 1'b1, "R6 ae at one word", DW'(b_almost_empty), DW'(1));
   endtask

   task automatic t_order_and_gating();
      for (int i = 1; i < 5; i++) push(36'hA_0000_0000 + DW'(i));
      settle();
      chk(b_almost_empty === 1'b0, "R6 ae clear at five words", DW'(b_almost_empty), DW'(0));
      // R8: enable low must not consume the head word
      @(negedge clk_b);
      b_sel = 1'b1; b_rd = 1'b1; b_en = 1'b0;
      @(negedge clk_b);
      b_sel = 1'b0;
      chk(b_data === 36'hA_0000_0000, "R8 head kept with enable low", b_data, 36'hA_0000_0000);
      for (int i = 0; i < 5; i++) begin
         pop_chk(36'hA_0000_0000 + DW'(i), "R3 order");
         if (i == 1) chk(b_almost_empty === 1'b1, "R6 ae at three words", DW'(b_almost_empty), DW'(1));
      end
      chk(b_valid === 1'b0, "R3 valid drops when empty", DW'(b_valid), DW'(0));
   endtask

   task automatic t_replay();
      set_mark();
      for (int i = 0; i < 4; i++) push(36'hB_0000_0000 + DW'(i));
      settle();
      pop_chk(36'hB_0000_0000, "R9 first pass");
      pop_chk(36'hB_0000_0001, "R9 first pass");
      set_mark();
      pop_chk(36'hB_0000_0002, "R9 first pass");
      pop_chk(36'hB_0000_0003, "R9 first pass");
      chk(b_valid === 1'b0, "R9 empty before rewind", DW'(b_valid), DW'(0));
      do_rewind();
      chk(b_valid === 1'b1, "R9 valid after rewind", DW'(b_valid), DW'(1));
      chk(b_data === 36'hB_0000_0002, "R9 replay starts at mark", b_data, 36'hB_0000_0002);
      pop_chk(36'hB_0000_0002, "R9 replay");
      pop_chk(36'hB_0000_0003, "R9 replay");
      chk(b_valid === 1'b0, "R9 empty after replay", DW'(b_valid), DW'(0));
   endtask

   task automatic t_space_from_mark();
      settle();
      // Two words (B2, B3) remain held from the mark, so fourteen more fit
      for (int k = 1; k <= 14; k++) begin
         chk(a_ready === 1'b1, "R10 ready before capacity", DW'(a_ready), DW'(1));
         push(36'hC_0000_0000 + DW'(k));
         if (k == 10) chk(a_almost_full === 1'b0, "R5 af clear at free four", DW'(a_almost_full), DW'(0));
         if (k == 11) chk(a_almost_full === 1'b1, "R5 af set at free three", DW'(a_almost_full), DW'(1));
      end
      chk(a_ready === 1'b0, "R4 ready low at capacity", DW'(a_ready), DW'(0));
      push(36'hD_EAD_0BAD);
      settle();
      for (int k = 1; k <= 14; k++) pop_chk(36'hC_0000_0000 + DW'(k), "R4 stored data intact");
      chk(b_valid === 1'b0, "R4 refused word not stored", DW'(b_valid), DW'(0));
      settle();
      chk(a_ready === 1'b0, "R10 space held after reading", DW'(a_ready), DW'(0));
      set_mark();
      settle();
      chk(a_ready === 1'b1, "R10 space freed by new mark", DW'(a_ready), DW'(1));
      chk(a_almost_full === 1'b0, "R10 af clear after new mark", DW'(a_almost_full), DW'(0));
   endtask

   task automatic t_program();
      a_cmd(1'b0, (DW'(6) << 16) | DW'(5));
      settle();
      chk(b_valid === 1'b0, "R7 load stores no word", DW'(b_valid), DW'(0));
      for (int i = 0; i < 6; i++) push(36'hE_0000_0000 + DW'(i));
      settle();
      chk(b_almost_empty === 1'b1, "R7 ae at loaded six", DW'(b_almost_empty), DW'(1));
      push(36'hE_0000_0006);
      settle();
      chk(b_almost_empty === 1'b0, "R7 ae clear at seven", DW'(b_almost_empty), DW'(0));
      for (int i = 7; i < 10; i++) push(36'hE_0000_0000 + DW'(i));
      chk(a_almost_full === 1'b0, "R7 af clear at free six", DW'(a_almost_full), DW'(0));
      push(36'hE_0000_000A);
      chk(a_almost_full === 1'b1, "R7 af set at loaded five", DW'(a_almost_full), DW'(1));
      settle();
      for (int i = 0; i < 11; i++) pop_chk(36'hE_0000_0000 + DW'(i), "R3 order after load");
      chk(b_valid === 1'b0, "R3 empty at end", DW'(b_valid), DW'(0));
   endtask

   initial begin
      t_reset();
      t_fall_through();
      t_order_and_gating();
      t_replay();
      t_space_from_mark();
      t_program();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk_a);
      chk(1'b0, "watchdog", '0, DW'(1));
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule